// File: doc/BRIEF.md
# Chip-Select Decoder with Per-Range Wait States

This block sits between a CPU's address bus and its external memory pins. Each address falls in one of eight fixed 2 MB pages. Pages 0 through 5 map to six external ranges, 12 MB in all, and each range has its own active-low chip-select. A 4 KB on-chip SRAM window sits at the base of page 6. Any other address, and any address inside a disabled range, is a decode error.

Each range holds three settings: an enable, a data-bus width (8-bit or 16-bit) and a wait-state count. When an access is accepted, the block takes a snapshot of the target range's settings. It then holds the chip-select and the width select for the stretched length of the access and signals completion. After reset only range 0 is live, so a boot ROM at address zero can be fetched without any software setup.

The access interface uses valid/ready. The master raises `acc_valid` with `acc_addr` and holds both steady until it samples `acc_ready` high. The transfer completes on the cycle where both are high. The master may drop `acc_valid` on that cycle, or keep it high with a new address to start another access. The block never asserts `acc_ready` except to end an access it has accepted. Configuration writes use a plain write-enable port with no handshake.

Top module: `chip_select_decoder`

## Requirements
- R1: An accepted address whose bits [23:21] equal i, for i in 0..5 with range i enabled, drives `cs_n[i]` low for the whole access and keeps every other chip-select high.
- R2: At most one `cs_n` bit is low at any time, and all are high while no access is in progress.
- R3: After reset, range 0 is enabled with an 8-bit bus and 15 wait states, and ranges 1 to 5 are disabled.
- R4: With a wait count W for the selected range, `acc_ready` is high for exactly one cycle, W+1 clock edges after the edge that accepted the access.
- R5: `bus_wide` is high (16-bit) during an access to a range whose width bit is set, and low (8-bit) otherwise.
- R6: An address whose bits [23:12] equal 0xC00 raises `sram_sel`, asserts no chip-select and completes with zero wait states (ready 1 edge after acceptance).
- R7: An address in a disabled range, in page 7, or in page 6 outside the SRAM window asserts no chip-select, raises `dec_err` for the access and completes with zero wait states.
- R8: A configuration write with `cfg_we` high sets range `cfg_addr` (0..5) from `cfg_wdata`: bit 0 is the enable, bit 1 selects the 16-bit bus, bits [5:2] give the wait count. A write to index 6 or 7 changes no range.
- R9: A configuration write made during an access leaves that access's timing and selects unchanged, and it takes effect from the next accepted access.
- R10: `acc_ready` stays low while no access has been accepted, and an access is accepted only from the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access request valid |
| acc_addr | input | 24 | Access byte address, held while valid and not ready |
| acc_ready | output | 1 | Access completes this cycle |
| cs_n | output | 6 | External chip-selects, active low |
| bus_wide | output | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| sram_sel | output | 1 | Access targets the on-chip SRAM window |
| dec_err | output | 1 | Access matched no enabled target |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Range index to write |
| cfg_wdata | input | 6 | {wait[3:0], wide, enable} |

## Verification
A corrupted range setting shows up on the first access to that range. A wrong enable shows a missing chip-select or a spurious decode error in the cycle after acceptance. A wrong width shows at `bus_wide` in that same cycle. A wrong wait count moves the `acc_ready` pulse by one cycle per count, so latency is measured in exact edges. A stuck or miscounting wait counter shows as a ready pulse that is late, early or missing, or a chip-select held past completion. The bench catches these at the first idle cycle after the access.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_WAIT = 2'd1,
    ACC_DONE = 2'd2
  } acc_state_e;
endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs #(
  parameter int N_RANGES = 6,
  parameter int WAIT_W   = 4,
  parameter int IDX_W    = 3,
  localparam int CFG_W   = WAIT_W + 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [IDX_W-1:0]                  cfg_addr,
  input  logic [CFG_W-1:0]                  cfg_wdata,
  output logic [N_RANGES-1:0]               rng_en,
  output logic [N_RANGES-1:0]               rng_wide,
  output logic [N_RANGES-1:0][WAIT_W-1:0]   rng_wait
);
  localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

  for (genvar i = 0; i < N_RANGES; i++) begin : g_range
    localparam logic BOOT = (i == 0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rng_en[i]   <= BOOT;
        rng_wide[i] <= 1'b0;
        rng_wait[i] <= BOOT ? WAIT_MAX : '0;
      end else if (cfg_we && cfg_addr == IDX_W'(i)) begin
        rng_en[i]   <= cfg_wdata[0];
        rng_wide[i] <= cfg_wdata[1];
        rng_wait[i] <= cfg_wdata[CFG_W-1:2];
      end
    end
  end

  // R8: settings move only after a write that names a real range
  assert_cfg_change_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(rng_en) && $stable(rng_wide) && $stable(rng_wait))
      |-> $past(cfg_we && (cfg_addr < IDX_W'(N_RANGES))));
endmodule

// File: rtl/csd_addr_decode.sv
module csd_addr_decode #(
  parameter int          N_RANGES  = 6,
  parameter int          WAIT_W    = 4,
  parameter int          ADDR_W    = 24,
  parameter int          PAGE_W    = 21,
  parameter int          SRAM_AW   = 12,
  parameter logic [23:0] SRAM_BASE = 24'hC0_0000,
  localparam int         PIDX_W    = ADDR_W - PAGE_W
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [N_RANGES-1:0]             rng_en,
  input  logic [N_RANGES-1:0]             rng_wide,
  input  logic [N_RANGES-1:0][WAIT_W-1:0] rng_wait,
  output logic [N_RANGES-1:0]             hit,
  output logic                            is_sram,
  output logic                            is_err,
  output logic                            sel_wide,
  output logic [WAIT_W-1:0]               sel_wait
);
  logic [PIDX_W-1:0] page;
  logic              unused_low;

  assign page       = addr[ADDR_W-1:PAGE_W];
  assign unused_low = ^addr[SRAM_AW-1:0];

  for (genvar i = 0; i < N_RANGES; i++) begin : g_hit
    assign hit[i] = rng_en[i] && (page == PIDX_W'(i));
  end

  assign is_sram = (addr[ADDR_W-1:SRAM_AW] == SRAM_BASE[ADDR_W-1:SRAM_AW]);
  assign is_err  = !(|hit) && !is_sram;

  always_comb begin
    sel_wide = 1'b0;
    sel_wait = '0;
    for (int i = 0; i < N_RANGES; i++) begin
      if (hit[i]) begin
        sel_wide = sel_wide | rng_wide[i];
        sel_wait = sel_wait | rng_wait[i];
      end
    end
  end
endmodule

// File: rtl/csd_access_ctrl.sv
module csd_access_ctrl
  import csd_pkg::*;
#(
  parameter int N_RANGES = 6,
  parameter int WAIT_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic [N_RANGES-1:0] hit,
  input  logic                is_sram,
  input  logic                is_err,
  input  logic                sel_wide,
  input  logic [WAIT_W-1:0]   sel_wait,
  output logic                acc_ready,
  output logic [N_RANGES-1:0] cs_n,
  output logic                bus_wide,
  output logic                sram_sel,
  output logic                dec_err
);
  acc_state_e          state;
  logic [WAIT_W-1:0]   cnt;
  logic [N_RANGES-1:0] cs_q;
  logic                wide_q, sram_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ACC_IDLE;
      cnt    <= '0;
      cs_q   <= '0;
      wide_q <= 1'b0;
      sram_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (state)
        ACC_IDLE: if (acc_valid) begin
          state  <= ACC_WAIT;
          cnt    <= sel_wait;
          cs_q   <= hit;
          wide_q <= sel_wide;
          sram_q <= is_sram;
          err_q  <= is_err;
        end
        ACC_WAIT: begin
          if (cnt == '0) state <= ACC_DONE;
          else           cnt   <= cnt - 1'b1;
        end
        ACC_DONE: begin
          state  <= ACC_IDLE;
          cs_q   <= '0;
          wide_q <= 1'b0;
          sram_q <= 1'b0;
          err_q  <= 1'b0;
        end
        default: state <= ACC_IDLE;
      endcase
    end
  end

  assign acc_ready = (state == ACC_DONE);
  assign cs_n      = ~cs_q;
  assign bus_wide  = wide_q;
  assign sram_sel  = sram_q;
  assign dec_err   = err_q;

  assert_single_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_q));
  assert_idle_no_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ACC_IDLE) |-> (cs_q == '0));
  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |=> !acc_ready);
  assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ACC_WAIT && cnt != '0) |=>
      (state == ACC_WAIT && cnt == WAIT_W'($past(cnt) - 1'b1)));
  assert_onchip_zero_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ACC_IDLE && acc_valid && hit == '0) |=> (state == ACC_WAIT && cnt == '0));
  assert_sram_no_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_q |-> (cs_q == '0));
  assert_err_no_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (cs_q == '0 && !sram_q));
  assert_hold_selects_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ACC_IDLE && $past(state) != ACC_IDLE) |-> ($stable(cs_q) && $stable(wide_q)));
  assert_ready_after_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> $past(state == ACC_WAIT));
endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder #(
  parameter int          N_RANGES  = 6,
  parameter int          WAIT_W    = 4,
  parameter int          ADDR_W    = 24,
  parameter int          PAGE_W    = 21,
  parameter int          SRAM_AW   = 12,
  parameter logic [23:0] SRAM_BASE = 24'hC0_0000,
  localparam int         IDX_W     = (N_RANGES > 1) ? $clog2(N_RANGES + 1) : 1,
  localparam int         CFG_W     = WAIT_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic [ADDR_W-1:0]   acc_addr,
  output logic                acc_ready,
  output logic [N_RANGES-1:0] cs_n,
  output logic                bus_wide,
  output logic                sram_sel,
  output logic                dec_err,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata
);
  logic [N_RANGES-1:0]             rng_en, rng_wide, hit;
  logic [N_RANGES-1:0][WAIT_W-1:0] rng_wait;
  logic                            is_sram, is_err, sel_wide;
  logic [WAIT_W-1:0]               sel_wait;

  csd_cfg_regs #(.N_RANGES(N_RANGES), .WAIT_W(WAIT_W), .IDX_W(IDX_W)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .rng_en, .rng_wide, .rng_wait
  );

  csd_addr_decode #(
    .N_RANGES(N_RANGES), .WAIT_W(WAIT_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .SRAM_AW(SRAM_AW), .SRAM_BASE(SRAM_BASE)
  ) u_dec (
    .addr(acc_addr), .rng_en, .rng_wide, .rng_wait,
    .hit, .is_sram, .is_err, .sel_wide, .sel_wait
  );

  csd_access_ctrl #(.N_RANGES(N_RANGES), .WAIT_W(WAIT_W)) u_ctrl (
    .clk, .rst_n, .acc_valid, .hit, .is_sram, .is_err, .sel_wide, .sel_wait,
    .acc_ready, .cs_n, .bus_wide, .sram_sel, .dec_err
  );

  // R1: the decoder never claims a range and the SRAM window at once
  assert_target_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_sram && (|hit)) && (is_err == (hit == '0 && !is_sram)) && $onehot0(hit));
endmodule

// File: tb/tb_chip_select_decoder.sv
`timescale 1ns/1ps
module tb_chip_select_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [23:0] acc_addr = '0;
  logic        acc_ready;
  logic [5:0]  cs_n;
  logic        bus_wide, sram_sel, dec_err;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [5:0]  cfg_wdata = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  chip_select_decoder dut (
    .clk, .rst_n, .acc_valid, .acc_addr, .acc_ready, .cs_n, .bus_wide,
    .sram_sel, .dec_err, .cfg_we, .cfg_addr, .cfg_wdata
  );

  // Vector table: addr, expected range (7 = none), wide, sram, err, waits
  localparam int NV = 12;
  localparam logic [23:0] V_ADDR [NV] = '{24'h000010, 24'h2ABCDE, 24'h400000, 24'h600004,
    24'h9FFFFE, 24'hA00000, 24'hBFFFFF, 24'hC00000, 24'hC00FFC, 24'hC01000, 24'hFFFFFF, 24'h1FFFFF};
  localparam int V_IDX  [NV] = '{0, 1, 2, 7, 4, 5, 5, 7, 7, 7, 7, 0};
  localparam bit V_WIDE [NV] = '{0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0};
  localparam bit V_SRAM [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0};
  localparam bit V_ERR  [NV] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1, 0};
  localparam int V_WAIT [NV] = '{15, 3, 0, 0, 7, 1, 1, 0, 0, 0, 0, 15};

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int csn_of(int idx);
    return (idx < 6) ? int'(~(6'b1 << idx)) & 'h3F : 'h3F;
  endfunction

  task automatic wr_cfg(int idx, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(idx); cfg_wdata = 6'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_access(logic [23:0] a, int idx, bit wide, bit sram, bit err, int w, string req);
    int n;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a;
    @(negedge clk);
    check(req, "cs_n", int'(cs_n), csn_of(idx));
    check(req, "bus_wide", int'(bus_wide), int'(wide));
    check(req, "sram_sel", int'(sram_sel), int'(sram));
    check(req, "dec_err", int'(dec_err), int'(err));
    n = 1;
    while (!acc_ready && n < 40) begin @(negedge clk); n++; end
    check({req, " R4"}, "ready latency", n, w + 2);
    check(req, "cs_n at ready", int'(cs_n), csn_of(idx));
    check(req, "dec_err at ready", int'(dec_err), int'(err));
    acc_valid = 1'b0;
    @(negedge clk);
    check("R2", "cs_n idle", int'(cs_n), 'h3F);
    check("R4", "ready single", int'(acc_ready), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "reset cs_n", int'(cs_n), 'h3F);
    check("R10", "reset ready", int'(acc_ready), 0);
    check("R3", "reset flags", int'({bus_wide, sram_sel, dec_err}), 0);

    // Reset map: boot range 0 slow 8-bit, range 1 off
    do_access(24'h000000, 0, 0, 0, 0, 15, "R3");
    do_access(24'h200000, 7, 0, 0, 1, 0, "R3 R7");

    // R10: no ready without a request
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R10", "ready without valid", int'(acc_ready), 0);
    end

    // Program map (R8 format: {wait, wide, en})
    wr_cfg(1, (3 << 2) | 3);
    wr_cfg(2, 1);
    wr_cfg(3, 0);
    wr_cfg(4, (7 << 2) | 3);
    wr_cfg(5, (1 << 2) | 1);

    for (int v = 0; v < NV; v++)
      do_access(V_ADDR[v], V_IDX[v], V_WIDE[v], V_SRAM[v], V_ERR[v], V_WAIT[v], "R1 R5 R6 R7");

    // R8: writes to indices 6 and 7 are dropped
    wr_cfg(6, 'h3F);
    wr_cfg(7, 'h3F);
    do_access(24'h400000, 2, 0, 0, 0, 0, "R8");
    do_access(24'h600000, 7, 0, 0, 1, 0, "R8");
    do_access(24'hC00004, 7, 0, 1, 0, 0, "R8");

    // R9: rewrite range 5 while an access to it is in flight
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 24'hA00100;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 6'((9 << 2) | 3);
    n = 1;
    @(negedge clk);
    cfg_we = 1'b0;
    n++;
    check("R9", "bus_wide in flight", int'(bus_wide), 0);
    while (!acc_ready && n < 40) begin @(negedge clk); n++; end
    check("R9", "old latency kept", n, 3);
    acc_valid = 1'b0;
    @(negedge clk);
    do_access(24'hA00100, 5, 1, 0, 0, 9, "R9");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule